// File: doc/BRIEF.md
# Command-Queued SPI Master Sequencer

This block is an SPI master that executes a short list of commands held in local memories. Each command byte carries a chip-select pattern, a choice between the default 8-bit length and a globally programmed length, and a choice between a short fixed pause and a long programmable pause after the transfer. Each command slot pairs with a transmit word and a receive word at the same index.

Software fills the command and transmit memories through a simple write port, programs the global length code, the long-delay count and the SCK divider, sets master enable, chooses the first and last slots, and pulses `go`. The sequencer then walks the slots in order, wrapping past the top of the memory. For each slot it drives the chip selects, shifts the word in SPI mode 0 with the MSB first, stores the received bits, waits out the pause, and moves on. After the pause of the last slot it raises `done`. A low level on the shared slave-select input while the block is the master aborts everything and latches a mode fault.

Top module: `cmdq_spi_master`

## Requirements
- R1: After reset `cs`, `sck`, `busy`, `done`, `mst_en` and `mode_fault` are all 0.
- R2: A start runs slots `q_first` up to and including `q_last`, incrementing modulo 16. The received word of each slot is readable at that same slot index on `rx_addr`/`rx_data`. `done` rises and `busy` falls once the pause of the last slot ends. `done` clears when the next start is accepted.
- R3: Command bit 5 picks the length. With 0 the transfer is 8 bits. With 1 the length comes from `cfg_len`.
- R4: In `cfg_len`, codes 8 to 15 give 8 to 15 bits and code 0 gives 16 bits. The codes 1 to 7 give 8 bits.
- R5: Transfers are SPI mode 0 with the MSB first. `mosi` presents transmit bits len-1 down to 0. `miso` is sampled as `sck` rises. The received word is right-aligned with zero upper bits.
- R6: `cs` equals command bits 3:0 from the cycle after a slot is loaded until one cycle after its last falling SCK edge. It is all zero during the pause and while idle. `cs` never changes while `sck` is high.
- R7: With command bit 4 at 0 the pause is 17 clocks. Between slots `cs` is therefore zero for 18 clocks (pause plus one load cycle). After the last slot, `done` rises 17 clocks after `cs` drops.
- R8: With command bit 4 at 1 the pause is 32 x `cfg_dtl` clocks, and `cfg_dtl` = 0 gives 8192 clocks.
- R9: Each SCK half period lasts `cfg_div` clocks (0 acts as 1), and `sck` idles low.
- R10: A low `ss_n` while `mst_en` is 1 aborts the queue: `cs` goes to 0, `busy` and `mst_en` go to 0, and `mode_fault` is set without setting `done`. `mode_fault` stays set until `fault_clr` is pulsed. `en_set` restores `mst_en`.
- R11: A `go` pulse while `mst_en` is 0 starts nothing: `busy`, `cs` and `sck` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Memory write strobe |
| ld_tgt | input | 1 | Write target: 0 command memory (low 8 bits), 1 transmit memory |
| ld_addr | input | 4 | Slot index for writes |
| ld_data | input | 16 | Write data |
| rx_addr | input | 4 | Slot index for receive reads |
| rx_data | output | 16 | Received word at `rx_addr` |
| cfg_len | input | 4 | Global length code |
| cfg_dtl | input | 8 | Long-pause count |
| cfg_div | input | 8 | SCK half-period in clocks |
| q_first | input | 4 | First slot of the queue |
| q_last | input | 4 | Last slot of the queue |
| go | input | 1 | Start pulse |
| en_set | input | 1 | Pulse that sets master enable |
| fault_clr | input | 1 | Pulse that clears the mode fault |
| ss_n | input | 1 | Shared slave-select input, low is a fault in master mode |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs | output | 4 | Chip-select pattern of the active slot |
| mst_en | output | 1 | Master enable |
| busy | output | 1 | Queue in progress |
| done | output | 1 | Queue completed |
| mode_fault | output | 1 | Sticky mode fault |

## Verification
Randomly sized queues with random start slots, random chip-select patterns, lengths from both the default and every global code, and both pause kinds show whether each slot's bit count, serial data and gap come from its own command byte rather than a neighbour's. A queue that wraps from slot 14 to slot 1 separates true modulo stepping from a stop at the top of the memory. Directed runs with the reserved length codes and code 0 separate the fallback to 8 bits from 16 bits, and a zero long-pause count separates 8192 clocks from a zero pause. A slave-select pulse during a slow 16-bit transfer, followed by a start that must be ignored and a recovery run, tells an abort apart from a late stop or a lost enable.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
   localparam int CS_W  = 4;
   localparam int CMD_W = 8;

   // Command byte: pcs in [3:0], long pause select [4], global length select [5]
   typedef struct packed {
      logic [1:0]      spare;
      logic            len_sel;
      logic            dly_sel;
      logic [CS_W-1:0] pcs;
   } cmd_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_XFER = 2'd2,
      ST_GAP  = 2'd3
   } seq_st_t;
endpackage

// File: rtl/cmdq_len_dec.sv
module cmdq_len_dec #(
   parameter int DATA_W  = 16,
   parameter int CODE_W  = 4,
   parameter int DEF_LEN = 8,
   localparam int LEN_W  = $clog2(DATA_W + 1)
) (
   input  logic              use_code,
   input  logic [CODE_W-1:0] code,
   output logic [LEN_W-1:0]  len
);
   logic [LEN_W-1:0] code_ext;

   if (DEF_LEN >= DATA_W || DEF_LEN < 1) begin : g_bad_def
      $error("cmdq_len_dec: DEF_LEN out of range");
   end

   assign code_ext = LEN_W'(code);

   always_comb begin
      if (!use_code)                     len = LEN_W'(DEF_LEN);
      else if (code == '0)               len = LEN_W'(DATA_W);
      else if (code_ext < LEN_W'(DEF_LEN)) len = LEN_W'(DEF_LEN);
      else                               len = code_ext;
   end
endmodule

// File: rtl/cmdq_delay.sv
module cmdq_delay #(
   parameter int DTL_W    = 8,
   parameter int STD_DLY  = 17,
   parameter int DLY_UNIT = 32,
   parameter int DLY_ZERO = 8192,
   localparam int LONG_MAX = DLY_UNIT * ((1 << DTL_W) - 1),
   localparam int MAX_D    = (DLY_ZERO > LONG_MAX) ? DLY_ZERO : LONG_MAX,
   localparam int CNT_W    = $clog2(MAX_D + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             abort,
   input  logic             long_sel,
   input  logic [DTL_W-1:0] dtl,
   output logic             fin
);
   logic [CNT_W-1:0] amt;
   logic [CNT_W-1:0] cnt;
   logic             run;

   if (CNT_W <= DTL_W || STD_DLY < 1) begin : g_bad_cfg
      $error("cmdq_delay: counter configuration invalid");
   end

   always_comb begin
      if (!long_sel)        amt = CNT_W'(STD_DLY);
      else if (dtl == '0)   amt = CNT_W'(DLY_ZERO);
      else                  amt = CNT_W'(DLY_UNIT) * CNT_W'(dtl);
   end

   assign fin = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (abort) begin
         cnt <= '0;
         run <= 1'b0;
      end else if (load) begin
         cnt <= amt - CNT_W'(1);
         run <= 1'b1;
      end else if (run) begin
         if (cnt == '0) run <= 1'b0;
         else           cnt <= cnt - CNT_W'(1);
      end
   end
endmodule

// File: rtl/cmdq_shifter.sv
module cmdq_shifter #(
   parameter int DATA_W = 16,
   parameter int DIV_W  = 8,
   localparam int LEN_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              abort,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] tx,
   input  logic [DIV_W-1:0]  div,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic [DATA_W-1:0] rx,
   output logic              done
);
   logic [DATA_W-1:0] sr;
   logic [DIV_W-1:0]  dcnt;
   logic [DIV_W-1:0]  half;
   logic [LEN_W-1:0]  bcnt;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  shamt;
   logic              act;

   assign half  = (div == '0) ? DIV_W'(1) : div;
   assign shamt = LEN_W'(DATA_W) - len;
   assign mosi  = sr[DATA_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr    <= '0;
         rx    <= '0;
         dcnt  <= '0;
         bcnt  <= '0;
         len_q <= '0;
         sck   <= 1'b0;
         act   <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            act <= 1'b0;
            sck <= 1'b0;
         end else if (start) begin
            sr    <= tx << shamt;
            rx    <= '0;
            dcnt  <= '0;
            bcnt  <= '0;
            len_q <= len;
            sck   <= 1'b0;
            act   <= 1'b1;
         end else if (act) begin
            if (dcnt == half - DIV_W'(1)) begin
               dcnt <= '0;
               if (!sck) begin
                  sck <= 1'b1;
                  rx  <= {rx[DATA_W-2:0], miso};
               end else begin
                  sck <= 1'b0;
                  sr  <= sr << 1;
                  if (bcnt == len_q - LEN_W'(1)) begin
                     act  <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bcnt <= bcnt + LEN_W'(1);
                  end
               end
            end else begin
               dcnt <= dcnt + DIV_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/cmdq_spi_master.sv
module cmdq_spi_master
   import cmdq_pkg::*;
#(
   parameter int DEPTH      = 16,
   parameter int DATA_W     = 16,
   parameter int LEN_CODE_W = 4,
   parameter int DTL_W      = 8,
   parameter int DIV_W      = 8,
   parameter int STD_DLY    = 17,
   parameter int DLY_UNIT   = 32,
   parameter int DLY_ZERO   = 8192,
   parameter int SS_SYNC    = 1,
   localparam int PTR_W     = $clog2(DEPTH),
   localparam int LEN_W     = $clog2(DATA_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_we,
   input  logic                  ld_tgt,
   input  logic [PTR_W-1:0]      ld_addr,
   input  logic [DATA_W-1:0]     ld_data,
   input  logic [PTR_W-1:0]      rx_addr,
   output logic [DATA_W-1:0]     rx_data,
   input  logic [LEN_CODE_W-1:0] cfg_len,
   input  logic [DTL_W-1:0]      cfg_dtl,
   input  logic [DIV_W-1:0]      cfg_div,
   input  logic [PTR_W-1:0]      q_first,
   input  logic [PTR_W-1:0]      q_last,
   input  logic                  go,
   input  logic                  en_set,
   input  logic                  fault_clr,
   input  logic                  ss_n,
   input  logic                  miso,
   output logic                  sck,
   output logic                  mosi,
   output logic [CS_W-1:0]       cs,
   output logic                  mst_en,
   output logic                  busy,
   output logic                  done,
   output logic                  mode_fault
);
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("cmdq_spi_master: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 8 || DATA_W < CMD_W) begin : g_bad_width
      $error("cmdq_spi_master: DATA_W too small");
   end

   cmd_t              cmd_mem [DEPTH];
   logic [DATA_W-1:0] tx_mem  [DEPTH];
   logic [DATA_W-1:0] rx_mem  [DEPTH];

   seq_st_t           st;
   logic [PTR_W-1:0]  ptr;
   logic [PTR_W-1:0]  last_q;
   cmd_t              cur_cmd;
   cmd_t              ld_cmd;
   logic              ss_low;
   logic              fault_now;
   logic              sh_start;
   logic              sh_done;
   logic [DATA_W-1:0] sh_rx;
   logic [LEN_W-1:0]  sh_len;
   logic              dly_load;
   logic              dly_fin;

   // slave-select conditioning: synchronised or direct
   if (SS_SYNC != 0) begin : g_ss_sync
      logic [1:0] ss_ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ss_ff <= 2'b11;
         else        ss_ff <= {ss_ff[0], ss_n};
      end
      assign ss_low = !ss_ff[1];
   end else begin : g_ss_direct
      assign ss_low = !ss_n;
   end

   assign fault_now = mst_en && ss_low;
   assign ld_cmd    = cmd_mem[ptr];
   assign sh_start  = (st == ST_LOAD) && !fault_now;
   assign dly_load  = (st == ST_XFER) && sh_done && !fault_now;
   assign busy      = (st != ST_IDLE);
   assign rx_data   = rx_mem[rx_addr];

   always_ff @(posedge clk) begin
      if (ld_we && !ld_tgt) cmd_mem[ld_addr] <= cmd_t'(ld_data[CMD_W-1:0]);
      if (ld_we &&  ld_tgt) tx_mem[ld_addr]  <= ld_data;
      if ((st == ST_XFER) && sh_done) rx_mem[ptr] <= sh_rx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         ptr        <= '0;
         last_q     <= '0;
         cur_cmd    <= '0;
         cs         <= '0;
         mst_en     <= 1'b0;
         mode_fault <= 1'b0;
         done       <= 1'b0;
      end else begin
         if (fault_clr) mode_fault <= 1'b0;
         if (en_set)    mst_en     <= 1'b1;
         if (fault_now) begin
            st         <= ST_IDLE;
            cs         <= '0;
            mst_en     <= 1'b0;
            mode_fault <= 1'b1;
         end else begin
            unique case (st)
               ST_IDLE: if (go && mst_en) begin
                  ptr    <= q_first;
                  last_q <= q_last;
                  done   <= 1'b0;
                  st     <= ST_LOAD;
               end
               ST_LOAD: begin
                  cur_cmd <= ld_cmd;
                  cs      <= ld_cmd.pcs;
                  st      <= ST_XFER;
               end
               ST_XFER: if (sh_done) begin
                  cs <= '0;
                  st <= ST_GAP;
               end
               ST_GAP: if (dly_fin) begin
                  if (ptr == last_q) begin
                     st   <= ST_IDLE;
                     done <= 1'b1;
                  end else begin
                     ptr <= ptr + PTR_W'(1);
                     st  <= ST_LOAD;
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   cmdq_len_dec #(
      .DATA_W (DATA_W),
      .CODE_W (LEN_CODE_W),
      .DEF_LEN(8)
   ) u_len (
      .use_code(ld_cmd.len_sel),
      .code    (cfg_len),
      .len     (sh_len)
   );

   cmdq_shifter #(
      .DATA_W(DATA_W),
      .DIV_W (DIV_W)
   ) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .start(sh_start),
      .abort(fault_now),
      .len  (sh_len),
      .tx   (tx_mem[ptr]),
      .div  (cfg_div),
      .miso (miso),
      .sck  (sck),
      .mosi (mosi),
      .rx   (sh_rx),
      .done (sh_done)
   );

   cmdq_delay #(
      .DTL_W   (DTL_W),
      .STD_DLY (STD_DLY),
      .DLY_UNIT(DLY_UNIT),
      .DLY_ZERO(DLY_ZERO)
   ) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (dly_load),
      .abort   (fault_now),
      .long_sel(cur_cmd.dly_sel),
      .dtl     (cfg_dtl),
      .fin     (dly_fin)
   );
endmodule

// File: rtl/cmdq_spi_master_chk.sv
module cmdq_spi_master_chk #(
   parameter int CS_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [CS_W-1:0] cs,
   input logic            sck,
   input logic            busy,
   input logic            done,
   input logic            mst_en,
   input logic            mode_fault
);
   assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs == '0) && !sck);

   assert_cs_steady_high_sck_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(cs));

   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_fault_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_fault && !$past(mode_fault)) |-> (!mst_en && !busy && (cs == '0) && !$rose(done)));

   assert_start_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mst_en));
endmodule

bind cmdq_spi_master cmdq_spi_master_chk #(.CS_W(cmdq_pkg::CS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs        (cs),
   .sck       (sck),
   .busy      (busy),
   .done      (done),
   .mst_en    (mst_en),
   .mode_fault(mode_fault)
);

// File: tb/cmdq_spi_master_tb.sv
module cmdq_spi_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_we = 1'b0, ld_tgt = 1'b0;
   logic [3:0]  ld_addr = '0;
   logic [15:0] ld_data = '0;
   logic [3:0]  rx_addr = '0;
   logic [15:0] rx_data;
   logic [3:0]  cfg_len = '0;
   logic [7:0]  cfg_dtl = 8'd1;
   logic [7:0]  cfg_div = 8'd1;
   logic [3:0]  q_first = '0, q_last = '0;
   logic        go = 1'b0, en_set = 1'b0, fault_clr = 1'b0, ss_n = 1'b1;
   logic        miso;
   logic        sck, mosi, mst_en, busy, done, mode_fault;
   logic [3:0]  cs;

   always #5 clk = ~clk;

   cmdq_spi_master u_dut (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_tgt(ld_tgt), .ld_addr(ld_addr),
      .ld_data(ld_data), .rx_addr(rx_addr), .rx_data(rx_data), .cfg_len(cfg_len),
      .cfg_dtl(cfg_dtl), .cfg_div(cfg_div), .q_first(q_first), .q_last(q_last),
      .go(go), .en_set(en_set), .fault_clr(fault_clr), .ss_n(ss_n), .miso(miso),
      .sck(sck), .mosi(mosi), .cs(cs), .mst_en(mst_en), .busy(busy), .done(done),
      .mode_fault(mode_fault)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_len(input bit sel, input logic [3:0] code);
      if (!sel) return 8;
      if (code == 4'd0) return 16;
      if (code < 4'd8) return 8;
      return int'(code);
   endfunction

   function automatic int exp_dly(input bit sel, input logic [7:0] dtl);
      if (!sel) return 17;
      if (dtl == 8'd0) return 8192;
      return 32 * int'(dtl);
   endfunction

   // slave model and monitor, entry index = order of execution
   logic [15:0] sw   [16];
   int          elen [16];
   int          n_ent = 0;
   int          k = 0;
   logic [15:0] cap = '0;
   int          bits_a [16];
   logic [15:0] mosi_a [16];
   logic [3:0]  cs_a   [16];
   int          gap_a  [16];
   int          per_a  [16];
   int          pc = -1;
   int          gapc = 0;
   bit          cs_bad = 0;
   logic        prev_sck = 1'b0, prev_done = 1'b0;
   logic [3:0]  prev_cs = '0;

   function automatic logic slave_bit(input int e, input int kk);
      if (e < 0 || e > 15) return 1'b0;
      if (kk >= elen[e]) return 1'b0;
      return sw[e][elen[e]-1-kk];
   endfunction

   assign miso = slave_bit(n_ent, k);

   always @(negedge clk) begin
      if (done && !prev_done && n_ent > 0 && n_ent <= 16) gap_a[n_ent-1] = gapc;
      if (cs != 4'd0) begin
         if (prev_cs == 4'd0) begin
            if (n_ent > 0 && n_ent <= 16) gap_a[n_ent-1] = gapc;
            k = 0; cap = '0; pc = -1;
            if (n_ent < 16) begin cs_a[n_ent] = cs; per_a[n_ent] = -1; end
         end else if (n_ent < 16 && cs != cs_a[n_ent]) begin
            cs_bad = 1;
         end
         if (pc >= 0) pc++;
         if (sck && !prev_sck) begin
            cap = {cap[14:0], mosi};
            k++;
            if (pc < 0) pc = 0;
            else if (n_ent < 16 && per_a[n_ent] < 0) per_a[n_ent] = pc;
         end
      end else begin
         if (prev_cs != 4'd0) begin
            if (n_ent < 16) begin bits_a[n_ent] = k; mosi_a[n_ent] = cap; end
            n_ent++;
            gapc = 1;
         end else begin
            gapc++;
         end
      end
      prev_sck  = sck;
      prev_cs   = cs;
      prev_done = done;
   end

   task automatic wr(input logic tgt, input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      ld_we = 1'b1; ld_tgt = tgt; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic pulse_go();
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
   endtask

   // per-run entry description in execution order
   logic [7:0]  ocmd [4];
   logic [15:0] otx  [4];
   logic [15:0] osw  [4];

   task automatic run_q(input int first, input int n);
      int ln, dl;
      logic [15:0] msk;
      for (int i = 0; i < n; i++) begin
         wr(1'b0, 4'((first + i) % 16), {8'h00, ocmd[i]});
         wr(1'b1, 4'((first + i) % 16), otx[i]);
         sw[i]   = osw[i];
         elen[i] = exp_len(ocmd[i][5], cfg_len);
      end
      @(negedge clk);
      n_ent = 0; cs_bad = 0;
      q_first = 4'(first);
      q_last  = 4'((first + n - 1) % 16);
      pulse_go();
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(n_ent == n, "R2 entry count", n_ent, n);
      chk(!busy, "R2 busy low at done", int'(busy), 0);
      chk(!cs_bad, "R6 cs steady in slot", int'(cs_bad), 0);
      for (int i = 0; i < n && i < n_ent; i++) begin
         ln  = exp_len(ocmd[i][5], cfg_len);
         dl  = exp_dly(ocmd[i][4], cfg_dtl);
         msk = (ln == 16) ? 16'hFFFF : 16'((1 << ln) - 1);
         chk(bits_a[i] == ln, "R3 R4 bit count", bits_a[i], ln);
         chk(mosi_a[i] == (otx[i] & msk), "R5 mosi word", int'(mosi_a[i]), int'(otx[i] & msk));
         chk(cs_a[i] == ocmd[i][3:0], "R6 cs pattern", int'(cs_a[i]), int'(ocmd[i][3:0]));
         chk(per_a[i] == 2 * ((cfg_div == 0) ? 1 : int'(cfg_div)), "R9 sck period",
             per_a[i], 2 * ((cfg_div == 0) ? 1 : int'(cfg_div)));
         if (i == n - 1)
            chk(gap_a[i] == dl, "R7 R8 final pause", gap_a[i], dl);
         else
            chk(gap_a[i] == dl + 1, "R7 R8 slot gap", gap_a[i], dl + 1);
         rx_addr = 4'((first + i) % 16);
         #1;
         chk(rx_data == (osw[i] & msk), "R2 R5 rx word", int'(rx_data), int'(osw[i] & msk));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      int n, first;
      logic [3:0] codes [4];
      seed = 32'd2024;
      void'($urandom(seed));
      codes[0] = 4'd0; codes[1] = 4'd3; codes[2] = 4'd11; codes[3] = 4'd15;

      repeat (3) @(negedge clk);
      // R1 reset values
      chk(cs == 0 && !sck && !busy && !done && !mst_en && !mode_fault,
          "R1 reset outputs", int'({cs, sck, busy, done, mst_en, mode_fault}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs == 0 && !busy && !mst_en, "R1 after release", int'({cs, busy, mst_en}), 0);

      // R11 start without enable
      pulse_go();
      repeat (20) @(negedge clk);
      chk(!busy && cs == 0 && !sck, "R11 go ignored when disabled", int'({busy, cs, sck}), 0);

      @(negedge clk); en_set = 1'b1;
      @(negedge clk); en_set = 1'b0;

      // R4 code 0 gives 16 bits, standard pause
      cfg_len = 4'd0; cfg_div = 8'd1;
      ocmd[0] = 8'h23; otx[0] = 16'hA5C3; osw[0] = 16'h3C5A;
      run_q(5, 1);
      // R4 reserved code falls back to 8, two slots
      cfg_len = 4'd5; cfg_div = 8'd2;
      ocmd[0] = 8'h21; otx[0] = 16'h00F1; osw[0] = 16'h0096;
      ocmd[1] = 8'h08; otx[1] = 16'h1234; osw[1] = 16'hFF81;
      run_q(0, 2);
      // R8 zero count gives 8192
      cfg_dtl = 8'd0; cfg_len = 4'd9;
      ocmd[0] = 8'h35; otx[0] = 16'h01AB; osw[0] = 16'h0155;
      run_q(9, 1);
      // R2 wrap 14..1, R8 count 2
      cfg_dtl = 8'd2; cfg_len = 4'd12;
      ocmd[0] = 8'h11; otx[0] = 16'h0ABC; osw[0] = 16'h0F0F;
      ocmd[1] = 8'h22; otx[1] = 16'h0123; osw[1] = 16'h0777;
      ocmd[2] = 8'h04; otx[2] = 16'h00C7; osw[2] = 16'h0033;
      ocmd[3] = 8'h3F; otx[3] = 16'h0DEF; osw[3] = 16'h0EEE;
      run_q(14, 4);

      // random queues
      for (int t = 0; t < 24; t++) begin
         n = 1 + int'($urandom % 4);
         first = int'($urandom % 16);
         cfg_len = ($urandom % 2) ? codes[$urandom % 4] : 4'($urandom);
         cfg_dtl = 8'(1 + $urandom % 3);
         cfg_div = 8'($urandom % 4);
         for (int i = 0; i < n; i++) begin
            ocmd[i] = {2'b00, 1'($urandom), 1'($urandom), 4'(1 + $urandom % 15)};
            otx[i]  = 16'($urandom);
            osw[i]  = 16'($urandom);
         end
         run_q(first, n);
      end

      // R10 mode fault mid-transfer
      cfg_len = 4'd0; cfg_div = 8'd8; cfg_dtl = 8'd1;
      wr(1'b0, 4'd3, 16'h002C);
      wr(1'b1, 4'd3, 16'hBEEF);
      q_first = 4'd3; q_last = 4'd3;
      pulse_go();
      repeat (30) @(negedge clk);
      chk(busy && cs == 4'hC, "R6 cs during slow slot", int'(cs), 12);
      ss_n = 1'b0;
      repeat (6) @(negedge clk);
      chk(mode_fault, "R10 fault set", int'(mode_fault), 1);
      chk(!mst_en && !busy && cs == 0 && !sck, "R10 abort outputs", int'({mst_en, busy, cs, sck}), 0);
      chk(!done, "R10 no done on abort", int'(done), 0);
      ss_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(mode_fault, "R10 fault sticky", int'(mode_fault), 1);
      pulse_go();
      repeat (30) @(negedge clk);
      chk(!busy && cs == 0 && !sck, "R11 go ignored after fault", int'({busy, cs, sck}), 0);
      @(negedge clk); fault_clr = 1'b1;
      @(negedge clk); fault_clr = 1'b0;
      chk(!mode_fault, "R10 fault cleared", int'(mode_fault), 0);
      @(negedge clk); en_set = 1'b1;
      @(negedge clk); en_set = 1'b0;
      chk(mst_en, "R10 enable restored", int'(mst_en), 1);
      cfg_div = 8'd1;
      ocmd[0] = 8'h16; otx[0] = 16'h5A5A; osw[0] = 16'hC3C3;
      run_q(7, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule